// File: doc/BRIEF.md
# Strap-Configured Serial Boot Loader

This block brings a chip out of reset by copying a configuration image from a serial EEPROM into a 256-entry byte register file. When the power-on reset is released, it captures a set of strap pins once. Three of them form the low bits of the 7-bit EEPROM device address, whose upper four bits are fixed at `1010`. The fourth strap chooses which of two two-wire serial ports carries the transfer. The byte-level traffic goes through a simple request/acknowledge interface to an external two-wire master. The master and the watchdog counter are outside this block.

There are three reset causes, and they are sorted into two classes. Power-on and a watchdog expiry are full resets: every register returns to its default value, the sticky error flag clears, and a fresh download follows. Holding the active-low reset pin is a soft reset: the register contents are kept and, once the pin releases, the image is read again and written on top of them. This lets a second image add to or override the first one before normal operation begins.

The image starts with a two-byte length, most significant byte first. The indicated number of (register index, value) byte pairs follow. A negative acknowledge from the master aborts the transfer, keeps whatever was already written, raises the error flag and declares the loader ready.

Top module: `cfg_boot_loader`

## Requirements
- R1: `rd_dev` equals `1010` followed by the three `strap_addr` bits (bit 2 most significant) that were present at the first clock edge after `por_n` rises.
- R2: `rd_port` equals the `strap_port` level captured at that same edge: 0 selects port 0 and 1 selects port 1.
- R3: Strap changes after that capture are ignored, including across soft and watchdog resets; only a new power-on reset recaptures them.
- R4: A full reset (`por_n` low, or `wdog_expire` high at a clock edge) sets register entry i to the value i and clears `load_err`.
- R5: `ready` is low from the clock edge of any reset until the download that follows it completes or aborts.
- R6: While `pin_rst_n` is low, no read is requested and register contents are kept. After release, a new download starts from EEPROM byte address 0.
- R7: Image layout: bytes 0 and 1 hold the pair count N (byte 0 is the high byte). They are followed by N pairs, index byte then value byte, and each pair writes the value into the entry at that index. A later pair to the same index wins. A download issues exactly 2+2N reads.
- R8: N = 0 ends the download after the two length reads, with no register written.
- R9: A read answered with `rd_nack` ends the download at once. It sets `load_err`, which stays set until a full reset, and raises `ready`. Earlier writes are kept.
- R10: `rd_req` stays high with `rd_addr` unchanged until `rd_ack` or `rd_nack` is seen.
- R11: `cfg_rdata` shows the register entry selected by `cfg_raddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_n | input | 1 | External reset pin, active low, soft reset |
| wdog_expire | input | 1 | Watchdog expiry, synchronous full reset |
| strap_port | input | 1 | Port-select strap |
| strap_addr | input | 3 | Device address straps |
| rd_req | output | 1 | Byte read request to the two-wire master |
| rd_port | output | 1 | Selected serial port |
| rd_dev | output | 7 | EEPROM device address |
| rd_addr | output | 16 | EEPROM byte address |
| rd_ack | input | 1 | Read done, `rd_data` valid |
| rd_nack | input | 1 | Read failed |
| rd_data | input | 8 | Returned byte |
| cfg_raddr | input | 8 | Register file read index |
| cfg_rdata | output | 8 | Register file read data |
| ready | output | 1 | Download finished or aborted |
| load_err | output | 1 | Sticky download error |

## Verification
A sequencer that loses its place in the image shows up as a wrong number of reads or as values landing at the wrong indices, visible at `cfg_rdata` as soon as `ready` rises. A strap latch that reloads at the wrong time changes `rd_dev` or `rd_port` within one cycle of the strap pins moving. Reset misclassification shows up the cycle after the reset: defaults either return or survive at `cfg_rdata`, and `load_err` either clears or stays.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        S_HOLD,
        S_LEN_HI,
        S_LEN_LO,
        S_PAIR_IDX,
        S_PAIR_VAL,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/cfgld_rst_ctl.sv
module cfgld_rst_ctl
    import cfgld_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_rst_n,
    input  logic             wdog_expire,
    input  logic             strap_port,
    input  logic [SEL_W-1:0] strap_addr,
    output logic             full_rst,
    output logic             soft_hold,
    output logic             sel_port,
    output logic [SEL_W+3:0] dev_addr
);
    typedef struct packed {
        logic             armed;
        logic             port;
        logic [SEL_W-1:0] addr;
    } strap_t;

    strap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.port  = strap_port;
            st_d.addr  = strap_addr;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_rst  = wdog_expire;
    assign soft_hold = !pin_rst_n || !st_q.armed;
    assign sel_port  = st_q.port;
    assign dev_addr  = {DEV_PREFIX, st_q.addr};

    // R3: straps frozen once captured
    p_strap_frozen_r3: assert property (@(posedge clk) disable iff (!por_n)
        st_q.armed |=> ($stable(st_q.port) && $stable(st_q.addr) && st_q.armed));
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int EE_AW = 16,
    parameter int LEN_W = 16,
    parameter int RF_AW = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             full_rst,
    input  logic             soft_hold,
    input  logic             rd_ack,
    input  logic             rd_nack,
    input  logic [DW-1:0]    rd_data,
    output logic             rd_req,
    output logic [EE_AW-1:0] rd_addr,
    output logic             wr_en,
    output logic [RF_AW-1:0] wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic             ready,
    output logic             load_err
);
    localparam int HI_W = LEN_W - DW;

    typedef struct packed {
        seq_state_e       state;
        logic [EE_AW-1:0] ee_addr;
        logic [LEN_W-1:0] remain;
        logic [HI_W-1:0]  len_hi;
        logic [RF_AW-1:0] idx;
        logic             err;
    } seq_t;

    seq_t sq_d, sq_q;
    logic busy;

    assign busy = (sq_q.state == S_LEN_HI) || (sq_q.state == S_LEN_LO) ||
                  (sq_q.state == S_PAIR_IDX) || (sq_q.state == S_PAIR_VAL);

    always_comb begin
        sq_d    = sq_q;
        wr_en   = 1'b0;
        wr_addr = sq_q.idx;
        wr_data = rd_data;
        if (full_rst) begin
            sq_d.state = S_HOLD;
            sq_d.err   = 1'b0;
        end else if (soft_hold) begin
            sq_d.state = S_HOLD;
        end else if (sq_q.state == S_HOLD) begin
            sq_d.state   = S_LEN_HI;
            sq_d.ee_addr = '0;
        end else if (busy && rd_nack) begin
            sq_d.err   = 1'b1;
            sq_d.state = S_DONE;
        end else if (busy && rd_ack) begin
            sq_d.ee_addr = sq_q.ee_addr + 1'b1;
            unique case (sq_q.state)
                S_LEN_HI: begin
                    sq_d.len_hi = rd_data[HI_W-1:0];
                    sq_d.state  = S_LEN_LO;
                end
                S_LEN_LO: begin
                    sq_d.remain = {sq_q.len_hi, rd_data};
                    sq_d.state  = ({sq_q.len_hi, rd_data} == '0) ? S_DONE : S_PAIR_IDX;
                end
                S_PAIR_IDX: begin
                    sq_d.idx   = rd_data[RF_AW-1:0];
                    sq_d.state = S_PAIR_VAL;
                end
                S_PAIR_VAL: begin
                    wr_en       = 1'b1;
                    sq_d.remain = sq_q.remain - 1'b1;
                    sq_d.state  = (sq_q.remain == LEN_W'(1)) ? S_DONE : S_PAIR_IDX;
                end
                default: sq_d.state = S_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sq_q <= '{state: S_HOLD, default: '0};
        else        sq_q <= sq_d;
    end

    assign rd_req   = busy;
    assign rd_addr  = sq_q.ee_addr;
    assign ready    = (sq_q.state == S_DONE);
    assign load_err = sq_q.err;

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req && !rd_ack && !rd_nack && !full_rst && !soft_hold) |=> (rd_req && $stable(rd_addr)));
    p_nack_abort_r9: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req && rd_nack && !full_rst && !soft_hold) |=> (ready && load_err && !rd_req));
    p_reset_drops_ready_r5: assert property (@(posedge clk) disable iff (!por_n)
        (full_rst || soft_hold) |=> (!ready && !rd_req));
    p_err_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
        full_rst |=> !load_err);
endmodule

// File: rtl/cfgld_regfile.sv
module cfgld_regfile #(
    parameter int RF_AW = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             full_rst,
    input  logic             wr_en,
    input  logic [RF_AW-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [RF_AW-1:0] rd_idx,
    output logic [DW-1:0]    rd_val
);
    localparam int DEPTH = 1 << RF_AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = full_rst ? DW'(i) : mem_q[i];
        end
        if (!full_rst && wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(i);
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_val = mem_q[rd_idx];

    p_default_top_r4: assert property (@(posedge clk) disable iff (!por_n)
        full_rst |=> (mem_q[DEPTH-1] == DW'(DEPTH-1)));
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
    import cfgld_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int EE_AW = 16,
    parameter int LEN_W = 16,
    parameter int RF_AW = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_rst_n,
    input  logic             wdog_expire,
    input  logic             strap_port,
    input  logic [SEL_W-1:0] strap_addr,
    output logic             rd_req,
    output logic             rd_port,
    output logic [SEL_W+3:0] rd_dev,
    output logic [EE_AW-1:0] rd_addr,
    input  logic             rd_ack,
    input  logic             rd_nack,
    input  logic [DW-1:0]    rd_data,
    input  logic [RF_AW-1:0] cfg_raddr,
    output logic [DW-1:0]    cfg_rdata,
    output logic             ready,
    output logic             load_err
);
    logic             full_rst, soft_hold, wr_en;
    logic [RF_AW-1:0] wr_addr;
    logic [DW-1:0]    wr_data;

    cfgld_rst_ctl #(.SEL_W(SEL_W)) u_rst (
        .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .wdog_expire(wdog_expire),
        .strap_port(strap_port), .strap_addr(strap_addr),
        .full_rst(full_rst), .soft_hold(soft_hold),
        .sel_port(rd_port), .dev_addr(rd_dev)
    );

    cfgld_seq #(.EE_AW(EE_AW), .LEN_W(LEN_W), .RF_AW(RF_AW), .DW(DW)) u_seq (
        .clk(clk), .por_n(por_n), .full_rst(full_rst), .soft_hold(soft_hold),
        .rd_ack(rd_ack), .rd_nack(rd_nack), .rd_data(rd_data),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ready(ready), .load_err(load_err)
    );

    cfgld_regfile #(.RF_AW(RF_AW), .DW(DW)) u_rf (
        .clk(clk), .por_n(por_n), .full_rst(full_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_idx(cfg_raddr), .rd_val(cfg_rdata)
    );
endmodule

// File: tb/cfg_boot_loader_tb.sv
module cfg_boot_loader_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n, pin_rst_n, wdog_expire, strap_port;
    logic [2:0]  strap_addr;
    logic        rd_req, rd_port, rd_ack, rd_nack, ready, load_err;
    logic [6:0]  rd_dev;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data, cfg_raddr, cfg_rdata;

    int checks = 0, fails = 0;
    int reads = 0, stab_fail = 0;
    int nack_at = -1, lat = 0, wcnt = 0;
    logic [15:0] first_a = '0;
    logic [7:0]  img [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_boot_loader u_dut (
        .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .wdog_expire(wdog_expire),
        .strap_port(strap_port), .strap_addr(strap_addr),
        .rd_req(rd_req), .rd_port(rd_port), .rd_dev(rd_dev), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_nack(rd_nack), .rd_data(rd_data),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .ready(ready), .load_err(load_err)
    );

    // EEPROM responder behind the two-wire master; answers after lat waiting cycles
    always @(negedge clk) begin
        if (rd_ack || rd_nack) begin
            rd_ack  <= 1'b0;
            rd_nack <= 1'b0;
            wcnt    <= 0;
        end else if (rd_req) begin
            if (wcnt == 0) first_a <= rd_addr;
            if (wcnt < lat) begin
                wcnt <= wcnt + 1;
            end else begin
                if (wcnt > 0 && rd_addr !== first_a) stab_fail <= stab_fail + 1; // R10
                reads <= reads + 1;
                if (int'(rd_addr) == nack_at) rd_nack <= 1'b1;
                else begin
                    rd_ack  <= 1'b1;
                    rd_data <= (rd_addr < 64) ? img[rd_addr[5:0]] : 8'h00;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [7:0] idx, input logic [7:0] exp, input string req);
        cfg_raddr = idx;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic clear_img();
        for (int i = 0; i < 64; i++) img[i] = 8'h00;
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!ready);
    endtask

    task automatic soft_reset();
        @(negedge clk);
        pin_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        pin_rst_n = 1'b1;
    endtask

    // {index, expected value} after the first download
    localparam logic [15:0] VEC [6] = '{
        {8'h10, 8'hCC}, {8'h20, 8'hBB}, {8'h00, 8'h00},
        {8'hFF, 8'hFF}, {8'h11, 8'h11}, {8'h30, 8'h30}
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int base;
        por_n = 1'b0; pin_rst_n = 1'b1; wdog_expire = 1'b0;
        strap_port = 1'b1; strap_addr = 3'd5;
        rd_ack = 1'b0; rd_nack = 1'b0; rd_data = '0; cfg_raddr = '0;
        clear_img();
        // image: N=3, (10,AA) (20,BB) (10,CC)
        img[0] = 8'h00; img[1] = 8'h03;
        img[2] = 8'h10; img[3] = 8'hAA; img[4] = 8'h20; img[5] = 8'hBB;
        img[6] = 8'h10; img[7] = 8'hCC;
        repeat (3) @(negedge clk);
        chk("R5 ready in reset", ready, 0);
        chk("R4 err in reset", load_err, 0);
        rd_reg(8'h03, 8'h03, "R4 default");

        base = reads;
        por_n = 1'b1;
        repeat (2) @(negedge clk);
        strap_port = 1'b0; strap_addr = 3'd2;
        wait_ready();
        chk("R1 device address", rd_dev, 7'b1010101);
        chk("R2 port select", rd_port, 1);
        chk("R7 read count 2+2N", reads - base, 8);
        chk("R7 no error", load_err, 0);
        for (int i = 0; i < 6; i++) rd_reg(VEC[i][15:8], VEC[i][7:0], "R7/R11 table");

        // soft reset with slow responder, N=1 (30,5A)
        clear_img();
        img[1] = 8'h01; img[2] = 8'h30; img[3] = 8'h5A;
        lat = 2;
        base = reads;
        @(negedge clk);
        pin_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 no request while pin low", rd_req, 0);
        chk("R5 ready low while pin low", ready, 0);
        pin_rst_n = 1'b1;
        wait_ready();
        rd_reg(8'h10, 8'hCC, "R6 soft reset keeps registers");
        rd_reg(8'h30, 8'h5A, "R6 second download applied");
        chk("R6 restart from address 0 read count", reads - base, 4);
        chk("R3 straps ignored after capture", rd_dev, 7'b1010101);
        chk("R10 request stable while waiting", stab_fail, 0);
        lat = 0;

        // N = 0
        clear_img();
        base = reads;
        soft_reset();
        wait_ready();
        chk("R8 only length reads", reads - base, 2);
        rd_reg(8'h30, 8'h5A, "R8 no write");

        // NACK on the second pair's index byte
        clear_img();
        img[1] = 8'h02; img[2] = 8'h40; img[3] = 8'h11; img[4] = 8'h41; img[5] = 8'h22;
        nack_at = 4;
        soft_reset();
        wait_ready();
        chk("R9 error set", load_err, 1);
        rd_reg(8'h40, 8'h11, "R9 earlier write kept");
        rd_reg(8'h41, 8'h41, "R9 later pair not written");
        nack_at = -1;
        clear_img();
        soft_reset();
        wait_ready();
        chk("R9 error sticky across soft reset", load_err, 1);

        // watchdog full reset
        @(negedge clk);
        wdog_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0;
        chk("R5 ready drops on watchdog", ready, 0);
        chk("R4 error cleared", load_err, 0);
        rd_reg(8'h10, 8'h10, "R4 default restored");
        wait_ready();
        rd_reg(8'h40, 8'h40, "R4 default after reload");
        chk("R3 straps kept over watchdog", rd_dev, 7'b1010101);
        chk("R2 port kept over watchdog", rd_port, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule